// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write hazards for a five-stage in-order integer pipeline. Each instruction carries a destination register number and two source register numbers. The block accepts the register fields of the instruction held in the decode stage. It advances them through its own copies of the execute, memory and write-back stage records. For the instruction in execute, it drives one 2-bit operand select for each source, so the ALU takes the newest in-flight value instead of a stale register-file read. Software needs no no-ops and no reordering.

A load produces its data one stage later than an ALU operation. When a load in execute writes a register that the decode-stage instruction reads, the block raises a stall for one cycle. The surrounding pipeline holds fetch and decode during that cycle, and the block places a bubble into its execute record. The select encoding is fixed: 00 selects the register file, 01 the memory-stage result and 10 the write-back-stage result.

Top module: `fwd_unit`

## Requirements
- R1: After reset all stage records are empty, so both selects read 00 and stall_o is 0.
- R2: A source of the valid execute instruction that equals the destination of a valid, register-writing memory-stage instruction gets select 01.
- R3: A source that matches only a valid, register-writing write-back-stage destination gets select 10.
- R4: When the memory and write-back stages both hold a matching destination, the memory stage (the younger instruction) wins and the select is 01.
- R5: Register 0 never produces a forwarding match; a source of 0 always gets select 00.
- R6: An older instruction that is invalid, or that does not write a register, is never a forwarding source.
- R7: stall_o is 1 in the same cycle that a valid load in execute writes a nonzero register read by either source of the valid decode-stage instruction.
- R8: A stall lasts exactly one cycle and places a bubble in execute, where both selects read 00. On the next cycle the held consumer enters execute and takes the load result from write-back (select 10).
- R9: The two source selects are computed independently of each other.
- R10: A producer three or more instructions older than the consumer is no longer in flight, and the select is 00.
- R11: A load whose destination is register 0, or whose destination no decode source reads, does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_rd_i | input | REG_W | Decode destination register |
| id_rs_a_i | input | REG_W | Decode source A register |
| id_rs_b_i | input | REG_W | Decode source B register |
| id_we_i | input | 1 | Decode instruction writes its destination |
| id_load_i | input | 1 | Decode instruction is a load |
| fwd_a_sel_o | output | 2 | Execute source A select (00 file, 01 memory, 10 write-back) |
| fwd_b_sel_o | output | 2 | Execute source B select |
| stall_o | output | 1 | Hold fetch and decode; bubble into execute |

## Verification
The assertions assume that the pipeline around the block holds the decode-stage fields unchanged while stall_o is high, and that id_load_i is asserted only together with id_we_i. The bench drives decode fields only at falling edges and keeps the consumer fields stable across the stall cycle. It also issues loads only as register-writing instructions. Between scenarios it drains the stage records with invalid instructions, so that leftover producers cannot create matches that a scenario does not expect.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_stage_regs.sv
module fwd_stage_regs #(
  parameter int unsigned REG_W = 5,
  localparam int unsigned NSRC = fwd_pkg::NUM_SRC
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       stall_i,
  input  logic                       id_valid_i,
  input  logic [REG_W-1:0]           id_rd_i,
  input  logic [NSRC-1:0][REG_W-1:0] id_rs_i,
  input  logic                       id_we_i,
  input  logic                       id_load_i,
  output logic                       ex_valid_o,
  output logic [REG_W-1:0]           ex_rd_o,
  output logic [NSRC-1:0][REG_W-1:0] ex_rs_o,
  output logic                       ex_we_o,
  output logic                       ex_load_o,
  output logic                       mem_valid_o,
  output logic [REG_W-1:0]           mem_rd_o,
  output logic                       mem_we_o,
  output logic                       wb_valid_o,
  output logic [REG_W-1:0]           wb_rd_o,
  output logic                       wb_we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_valid_o  <= 1'b0;
      ex_rd_o     <= '0;
      ex_rs_o     <= '0;
      ex_we_o     <= 1'b0;
      ex_load_o   <= 1'b0;
      mem_valid_o <= 1'b0;
      mem_rd_o    <= '0;
      mem_we_o    <= 1'b0;
      wb_valid_o  <= 1'b0;
      wb_rd_o     <= '0;
      wb_we_o     <= 1'b0;
    end else begin
      // bubble on stall: decode is held upstream
      ex_valid_o  <= id_valid_i & ~stall_i;
      ex_rd_o     <= id_rd_i;
      ex_rs_o     <= id_rs_i;
      ex_we_o     <= id_we_i & ~stall_i;
      ex_load_o   <= id_load_i & ~stall_i;
      mem_valid_o <= ex_valid_o;
      mem_rd_o    <= ex_rd_o;
      mem_we_o    <= ex_we_o;
      wb_valid_o  <= mem_valid_o;
      wb_rd_o     <= mem_rd_o;
      wb_we_o     <= mem_we_o;
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int unsigned REG_W = 5
) (
  input  logic                    ex_valid_i,
  input  logic [REG_W-1:0]        src_i,
  input  logic                    mem_valid_i,
  input  logic [REG_W-1:0]        mem_rd_i,
  input  logic                    mem_we_i,
  input  logic                    wb_valid_i,
  input  logic [REG_W-1:0]        wb_rd_i,
  input  logic                    wb_we_i,
  output fwd_pkg::fwd_sel_e       sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = ex_valid_i && (src_i != '0);
  assign mem_hit  = src_live && mem_valid_i && mem_we_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_valid_i && wb_we_i && (wb_rd_i == src_i);

  always_comb begin
    if (mem_hit)     sel_o = fwd_pkg::SEL_MEM;
    else if (wb_hit) sel_o = fwd_pkg::SEL_WB;
    else             sel_o = fwd_pkg::SEL_RF;
  end
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
  parameter int unsigned REG_W = 5,
  localparam int unsigned NSRC = fwd_pkg::NUM_SRC
) (
  input  logic                       ex_valid_i,
  input  logic                       ex_load_i,
  input  logic                       ex_we_i,
  input  logic [REG_W-1:0]           ex_rd_i,
  input  logic                       id_valid_i,
  input  logic [NSRC-1:0][REG_W-1:0] id_rs_i,
  output logic                       stall_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = (id_rs_i[g] == ex_rd_i);
  end

  assign stall_o = ex_valid_i && ex_load_i && ex_we_i && (ex_rd_i != '0)
                   && id_valid_i && (|hit);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic [REG_W-1:0] id_rd_i,
  input  logic [REG_W-1:0] id_rs_a_i,
  input  logic [REG_W-1:0] id_rs_b_i,
  input  logic             id_we_i,
  input  logic             id_load_i,
  output logic [1:0]       fwd_a_sel_o,
  output logic [1:0]       fwd_b_sel_o,
  output logic             stall_o
);
  localparam int unsigned NSRC = fwd_pkg::NUM_SRC;

  logic [NSRC-1:0][REG_W-1:0] id_rs, ex_rs;
  logic                       ex_valid, ex_we, ex_load;
  logic [REG_W-1:0]           ex_rd, mem_rd, wb_rd;
  logic                       mem_valid, mem_we, wb_valid, wb_we;
  fwd_pkg::fwd_sel_e          sel [NSRC];

  assign id_rs[0] = id_rs_a_i;
  assign id_rs[1] = id_rs_b_i;

  fwd_stage_regs #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .stall_i     (stall_o),
    .id_valid_i, .id_rd_i,
    .id_rs_i     (id_rs),
    .id_we_i, .id_load_i,
    .ex_valid_o  (ex_valid),
    .ex_rd_o     (ex_rd),
    .ex_rs_o     (ex_rs),
    .ex_we_o     (ex_we),
    .ex_load_o   (ex_load),
    .mem_valid_o (mem_valid),
    .mem_rd_o    (mem_rd),
    .mem_we_o    (mem_we),
    .wb_valid_o  (wb_valid),
    .wb_rd_o     (wb_rd),
    .wb_we_o     (wb_we)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    fwd_operand_sel #(.REG_W(REG_W)) u_sel (
      .ex_valid_i  (ex_valid),
      .src_i       (ex_rs[g]),
      .mem_valid_i (mem_valid),
      .mem_rd_i    (mem_rd),
      .mem_we_i    (mem_we),
      .wb_valid_i  (wb_valid),
      .wb_rd_i     (wb_rd),
      .wb_we_i     (wb_we),
      .sel_o       (sel[g])
    );
  end

  assign fwd_a_sel_o = sel[0];
  assign fwd_b_sel_o = sel[1];

  fwd_load_use #(.REG_W(REG_W)) u_lu (
    .ex_valid_i (ex_valid),
    .ex_load_i  (ex_load),
    .ex_we_i    (ex_we),
    .ex_rd_i    (ex_rd),
    .id_valid_i,
    .id_rs_i    (id_rs),
    .stall_o
  );
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       fwd_a_sel_o,
  input logic [1:0]       fwd_b_sel_o,
  input logic             stall_o,
  input logic             ex_valid,
  input logic [1:0][REG_W-1:0] ex_rs,
  input logic             mem_valid,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_we,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_we
);
  // R2: a memory select needs a live memory producer
  a_r2_mem_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_sel_o == 2'b01) |-> (mem_valid && mem_we && mem_rd == ex_rs[0]));

  // R4: write-back select only when memory does not match
  a_r4_wb_yields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_sel_o == 2'b10) |->
      (wb_valid && wb_we && wb_rd == ex_rs[1] &&
       !(mem_valid && mem_we && mem_rd == ex_rs[1])));

  // R5: register 0 is never forwarded
  a_r5_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs[0] == '0 || !ex_valid) |-> (fwd_a_sel_o == 2'b00));

  // R8: one stall cycle, then a bubble in execute
  a_r8_one_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (!stall_o && fwd_a_sel_o == 2'b00 && fwd_b_sel_o == 2'b00));

  // R2/R3: encoding 11 is never driven
  a_r3_legal_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_sel_o != 2'b11) && (fwd_b_sel_o != 2'b11));
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk_i, .rst_ni, .fwd_a_sel_o, .fwd_b_sel_o, .stall_o,
  .ex_valid, .ex_rs, .mem_valid, .mem_rd, .mem_we,
  .wb_valid, .wb_rd, .wb_we
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       id_valid_i = 1'b0;
  logic [4:0] id_rd_i = '0, id_rs_a_i = '0, id_rs_b_i = '0;
  logic       id_we_i = 1'b0, id_load_i = 1'b0;
  logic [1:0] fwd_a_sel_o, fwd_b_sel_o;
  logic       stall_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fwd_unit #(.REG_W(5)) u_dut (.*);

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive decode at falling edge, clock once, sample after the edge
  task automatic issue(input bit v, input int rd, input int ra, input int rb,
                       input bit we, input bit ld);
    @(negedge clk_i);
    id_valid_i = v; id_rd_i = 5'(rd); id_rs_a_i = 5'(ra); id_rs_b_i = 5'(rb);
    id_we_i = we; id_load_i = ld;
    @(posedge clk_i); #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 sel_a", fwd_a_sel_o, 2'b00);
    chk("R1 sel_b", fwd_b_sel_o, 2'b00);
    chk("R1 stall", {1'b0, stall_o}, 2'b00);
  endtask

  task automatic t_mem();
    drain();
    issue(1, 2, 1, 3, 1, 0);
    issue(1, 12, 2, 5, 1, 0);
    chk("R2 sel_a mem", fwd_a_sel_o, 2'b01);
    chk("R9 sel_b independent", fwd_b_sel_o, 2'b00);
  endtask

  task automatic t_wb();
    drain();
    issue(1, 4, 1, 1, 1, 0);
    issue(1, 5, 6, 7, 1, 0);
    issue(1, 13, 6, 4, 1, 0);
    chk("R3 sel_b wb", fwd_b_sel_o, 2'b10);
    chk("R9 sel_a no hit", fwd_a_sel_o, 2'b00);
  endtask

  task automatic t_both();
    drain();
    issue(1, 5, 4, 3, 1, 0);
    issue(1, 5, 5, 5, 1, 0);
    chk("R2 sel_a from mem", fwd_a_sel_o, 2'b01);
    chk("R3 sel_b from wb in mem", fwd_b_sel_o, 2'b01);
    issue(1, 14, 6, 6, 1, 0);
    issue(1, 15, 5, 5, 1, 0);
    chk("R3 sel_a wb only", fwd_a_sel_o, 2'b10);
    drain();
    issue(1, 6, 1, 1, 1, 0);
    issue(1, 6, 2, 2, 1, 0);
    issue(1, 7, 6, 6, 1, 0);
    chk("R4 sel_a younger wins", fwd_a_sel_o, 2'b01);
    chk("R4 sel_b younger wins", fwd_b_sel_o, 2'b01);
  endtask

  task automatic t_zero();
    drain();
    issue(1, 0, 1, 2, 1, 0);
    issue(1, 9, 0, 0, 1, 0);
    chk("R5 sel_a r0", fwd_a_sel_o, 2'b00);
    chk("R5 sel_b r0", fwd_b_sel_o, 2'b00);
  endtask

  task automatic t_nowrite();
    drain();
    issue(1, 8, 1, 2, 0, 0);
    issue(0, 8, 1, 2, 1, 0);
    issue(1, 9, 8, 8, 1, 0);
    chk("R6 no-write producer", fwd_b_sel_o, 2'b00);
    chk("R6 invalid producer", fwd_a_sel_o, 2'b00);
  endtask

  task automatic t_old();
    drain();
    issue(1, 9, 1, 1, 1, 0);
    issue(0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0);
    issue(1, 10, 9, 9, 1, 0);
    chk("R10 producer retired", fwd_a_sel_o, 2'b00);
  endtask

  task automatic t_load();
    drain();
    issue(1, 10, 1, 2, 1, 1);
    @(negedge clk_i);
    id_valid_i = 1; id_rd_i = 5'd11; id_rs_a_i = 5'd3; id_rs_b_i = 5'd10;
    id_we_i = 1; id_load_i = 0;
    #1;
    chk("R7 load-use stall", {1'b0, stall_o}, 2'b01);
    @(posedge clk_i); #1;
    chk("R8 stall one cycle", {1'b0, stall_o}, 2'b00);
    chk("R8 bubble sel_a", fwd_a_sel_o, 2'b00);
    chk("R8 bubble sel_b", fwd_b_sel_o, 2'b00);
    @(posedge clk_i); #1;
    chk("R8 consumer from wb", fwd_b_sel_o, 2'b10);
    chk("R8 consumer sel_a", fwd_a_sel_o, 2'b00);
  endtask

  task automatic t_noload_stall();
    drain();
    issue(1, 0, 1, 2, 1, 1);
    @(negedge clk_i);
    id_valid_i = 1; id_rd_i = 5'd3; id_rs_a_i = 5'd0; id_rs_b_i = 5'd0;
    id_we_i = 1; id_load_i = 0;
    #1;
    chk("R11 load to r0", {1'b0, stall_o}, 2'b00);
    drain();
    issue(1, 12, 1, 2, 1, 1);
    @(negedge clk_i);
    id_valid_i = 1; id_rd_i = 5'd3; id_rs_a_i = 5'd4; id_rs_b_i = 5'd5;
    #1;
    chk("R11 unrelated load", {1'b0, stall_o}, 2'b00);
    id_rs_a_i = 5'd12;
    #1;
    chk("R7 stall on source A", {1'b0, stall_o}, 2'b01);
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_mem();
    t_wb();
    t_both();
    t_zero();
    t_nowrite();
    t_old();
    t_load();
    t_noload_stall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule